// File: doc/BRIEF.md
# Complementary PWM Polarity Control

This block sits between a PWM generator and the output pins of a complementary pair. A single 8-bit control register selects the active level of the positive-phase and negative-phase pins. It also chooses whether those levels come from the register itself or from a polarity pair supplied by an alternate settings register. A third control turns on a toggle output that changes state once per PWM period. The raw phase signals, a dead-time-enabled flag and a period-boundary strobe come in from outside. The block drives the final pin levels and the toggle output.

A write-once lock protects the level and source settings against runaway software. Once the lock is set after a power-on reset, it stays set and freezes the two level selects and the source select until the next power-on reset. The toggle enable remains writable while locked. A separate soft reset clears every other setting and leaves the lock as it is. Both resets are asserted asynchronously and released through synchronizers.

Top module: `pwm_pol_ctrl`

## Requirements
- R1: Once power-on reset is applied, the register reads 0x00. The toggle output is 0, and both pins drive the inverse of their raw signals.
- R2: Bits 4, 5 and 7 always read as 0, and any value written to them is discarded.
- R3: While unlocked, a write updates bit 0 (positive level select), bit 1 (negative level select), bit 2 (source select) and bit 6 (toggle enable). The new value reads back after the write cycle.
- R4: Writing 1 to bit 3 (lock) sets it. After that, writing 0 to bit 3 leaves it at 1 until the next power-on reset.
- R5: While the lock is 1, writes leave bits 0, 1 and 2 unchanged, and bit 6 is still written.
- R6: When bit 2 is 0, the register's level selects set the pin polarity. When bit 2 is 1, the alternate pair (alt_lvl_p, alt_lvl_n) is used, and register bits 0 and 1 have no effect.
- R7: A level value of 1 passes the raw phase signal to its pin unchanged. A level value of 0 inverts it.
- R8: When dt_en is 0, out_neg is always the inverse of out_pos, and the negative level select has no effect.
- R9: When bit 6 is 1, tgl_out inverts on the clock edge that samples period_strb high, and holds otherwise.
- R10: When bit 6 is 0, tgl_out is 0 from the next clock edge on. After re-enabling, it starts from 0.
- R11: Soft reset (rst_n low) clears bits 0, 1, 2 and 6 and the toggle output, and keeps the lock bit. Only power-on reset (por_n low) clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| rst_n | input | 1 | Soft reset, active low, asynchronous assert |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| dt_en | input | 1 | Dead time enabled for the pair |
| raw_pos | input | 1 | Raw positive-phase PWM |
| raw_neg | input | 1 | Raw negative-phase PWM |
| alt_lvl_p | input | 1 | Alternate positive level select |
| alt_lvl_n | input | 1 | Alternate negative level select |
| period_strb | input | 1 | One-cycle PWM period boundary strobe |
| out_pos | output | 1 | Final positive-phase pin |
| out_neg | output | 1 | Final negative-phase pin |
| tgl_out | output | 1 | Period-synchronous toggle output |

## Verification
The pin path is driven with all four combinations of raw_pos and raw_neg under each setting that changes the result: local levels 00, 01 and 11, alternate pairs that disagree with the local bits, and dead time on and off. Each combination separates pass-through from inversion on each pin independently. With dead time off, a differing negative level select shows whether out_neg tracks ~out_pos or its own input. Lock tests mix a blocked field change with a toggle-enable change in one write, which separates blocking the whole write from blocking only the protected fields. A soft reset followed by a power-on reset shows that the two resets clear different state.

// File: rtl/pwm_pol_pkg.sv
package pwm_pol_pkg;
  localparam int REG_W    = 8;
  localparam int LVLP_BIT = 0;
  localparam int LVLN_BIT = 1;
  localparam int SRC_BIT  = 2;
  localparam int LOCK_BIT = 3;
  localparam int TGLE_BIT = 6;

  // Fields cleared by soft reset and guarded by the lock (toggle enable excepted)
  localparam logic [REG_W-1:0] GUARD_MASK =
    (REG_W'(1) << LVLP_BIT) | (REG_W'(1) << LVLN_BIT) | (REG_W'(1) << SRC_BIT);
  localparam logic [REG_W-1:0] FREE_MASK  = REG_W'(1) << TGLE_BIT;
  localparam logic [REG_W-1:0] FIELD_MASK = GUARD_MASK | FREE_MASK;
  localparam logic [REG_W-1:0] RSVD_MASK  = ~(FIELD_MASK | (REG_W'(1) << LOCK_BIT));
endpackage

// File: rtl/pwm_pol_rst_sync.sv
module pwm_pol_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_pol_regs.sv
module pwm_pol_regs
  import pwm_pol_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         por_rn,
  input  logic         sys_rn,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         lvl_p,
  output logic         lvl_n,
  output logic         src_alt,
  output logic         tgl_en
);
  localparam logic [W-1:0] GMASK = W'(GUARD_MASK);
  localparam logic [W-1:0] FMASK = W'(FREE_MASK);

  logic [W-1:0] field_q, field_d, wmask;
  logic         lock_q, lock_d, field_ce;

  // Write mask narrows to the free field once locked
  always_comb begin
    wmask    = lock_q ? FMASK : (GMASK | FMASK);
    field_ce = wr_en;
    field_d  = (field_q & ~wmask) | (wdata & wmask);
    lock_d   = lock_q | (wr_en & wdata[LOCK_BIT]);
  end

  always_ff @(posedge clk or negedge sys_rn) begin
    if (!sys_rn)       field_q <= '0;
    else if (field_ce) field_q <= field_d;
  end

  // Sticky lock: cleared only by power-on reset
  always_ff @(posedge clk or negedge por_rn) begin
    if (!por_rn) lock_q <= 1'b0;
    else         lock_q <= lock_d;
  end

  always_comb begin
    rdata           = field_q;
    rdata[LOCK_BIT] = lock_q;
  end

  assign lvl_p   = field_q[LVLP_BIT];
  assign lvl_n   = field_q[LVLN_BIT];
  assign src_alt = field_q[SRC_BIT];
  assign tgl_en  = field_q[TGLE_BIT];
endmodule

// File: rtl/pwm_pol_path.sv
module pwm_pol_path (
  input  logic lvl_p,
  input  logic lvl_n,
  input  logic src_alt,
  input  logic alt_p,
  input  logic alt_n,
  input  logic dt_en,
  input  logic raw_pos,
  input  logic raw_neg,
  output logic pin_pos,
  output logic pin_neg
);
  logic sel_p, sel_n, pos_v;

  always_comb begin
    sel_p   = src_alt ? alt_p : lvl_p;
    sel_n   = src_alt ? alt_n : lvl_n;
    pos_v   = sel_p ? raw_pos : ~raw_pos;
    pin_pos = pos_v;
    pin_neg = dt_en ? (sel_n ? raw_neg : ~raw_neg) : ~pos_v;
  end
endmodule

// File: rtl/pwm_pol_toggle.sv
module pwm_pol_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic strobe,
  output logic tgl
);
  logic tgl_q, tgl_d;

  always_comb begin
    if (!en)         tgl_d = 1'b0;
    else if (strobe) tgl_d = ~tgl_q;
    else             tgl_d = tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= tgl_d;
  end

  assign tgl = tgl_q;
endmodule

// File: rtl/pwm_pol_ctrl.sv
module pwm_pol_ctrl
  import pwm_pol_pkg::*;
#(
  parameter int W           = REG_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         dt_en,
  input  logic         raw_pos,
  input  logic         raw_neg,
  input  logic         alt_lvl_p,
  input  logic         alt_lvl_n,
  input  logic         period_strb,
  output logic         out_pos,
  output logic         out_neg,
  output logic         tgl_out
);
  logic por_rn, sys_rn, sys_arst_n;
  logic lvl_p, lvl_n, src_alt, tgl_en;

  assign sys_arst_n = por_n & rst_n;

  pwm_pol_rst_sync #(.STAGES(SYNC_STAGES)) por_sync_i (
    .clk(clk), .arst_n(por_n), .srst_n(por_rn)
  );
  pwm_pol_rst_sync #(.STAGES(SYNC_STAGES)) sys_sync_i (
    .clk(clk), .arst_n(sys_arst_n), .srst_n(sys_rn)
  );

  pwm_pol_regs #(.W(W)) regs_i (
    .clk(clk), .por_rn(por_rn), .sys_rn(sys_rn),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .lvl_p(lvl_p), .lvl_n(lvl_n), .src_alt(src_alt), .tgl_en(tgl_en)
  );

  pwm_pol_path path_i (
    .lvl_p(lvl_p), .lvl_n(lvl_n), .src_alt(src_alt),
    .alt_p(alt_lvl_p), .alt_n(alt_lvl_n), .dt_en(dt_en),
    .raw_pos(raw_pos), .raw_neg(raw_neg),
    .pin_pos(out_pos), .pin_neg(out_neg)
  );

  pwm_pol_toggle tgl_i (
    .clk(clk), .rst_n(sys_rn), .en(tgl_en),
    .strobe(period_strb), .tgl(tgl_out)
  );
endmodule

// File: rtl/pwm_pol_ctrl_chk.sv
module pwm_pol_ctrl_chk
  import pwm_pol_pkg::*;
#(
  parameter int W = REG_W
) (
  input logic         clk,
  input logic         por_n,
  input logic         rst_n,
  input logic         wr_en,
  input logic [W-1:0] rdata,
  input logic         dt_en,
  input logic         period_strb,
  input logic         out_pos,
  input logic         out_neg,
  input logic         tgl_out
);
  localparam logic [W-1:0] RMASK = W'(RSVD_MASK);
  localparam logic [W-1:0] GMASK = W'(GUARD_MASK);

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!por_n)
    (rdata & RMASK) == '0);

  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!por_n)
    $past(rdata[LOCK_BIT]) |-> rdata[LOCK_BIT]);

  assert_locked_guard_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (rdata[LOCK_BIT] && wr_en) |=> ((rdata & GMASK) == ($past(rdata) & GMASK)));

  assert_no_dt_inverse_R8: assert property (@(posedge clk) disable iff (!por_n)
    !dt_en |-> (out_neg != out_pos));

  assert_tgl_flip_R9: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (rdata[TGLE_BIT] && period_strb) |=> (tgl_out != $past(tgl_out)));

  assert_tgl_off_R10: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !rdata[TGLE_BIT] |=> !tgl_out);
endmodule

bind pwm_pol_ctrl pwm_pol_ctrl_chk #(.W(W)) chk_i (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .rdata(rdata),
  .dt_en(dt_en), .period_strb(period_strb),
  .out_pos(out_pos), .out_neg(out_neg), .tgl_out(tgl_out)
);

// File: tb/pwm_pol_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwm_pol_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       por_n, rst_n, wr_en, dt_en, raw_pos, raw_neg;
  logic       alt_lvl_p, alt_lvl_n, period_strb;
  logic [7:0] wdata, rdata;
  logic       out_pos, out_neg, tgl_out;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  pwm_pol_ctrl dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .dt_en(dt_en), .raw_pos(raw_pos), .raw_neg(raw_neg),
    .alt_lvl_p(alt_lvl_p), .alt_lvl_n(alt_lvl_n), .period_strb(period_strb),
    .out_pos(out_pos), .out_neg(out_neg), .tgl_out(tgl_out)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0; rst_n = 1'b1; wr_en = 1'b0; wdata = '0; period_strb = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic strobe();
    @(negedge clk);
    period_strb = 1'b1;
    @(negedge clk);
    period_strb = 1'b0;
  endtask

  // Expected pins from register value and inputs
  function automatic logic [1:0] exp_pins(input logic [7:0] r, input logic ap, input logic an,
                                          input logic rp, input logic rn, input logic dt);
    logic lp, ln, p, n;
    lp = r[2] ? ap : r[0];
    ln = r[2] ? an : r[1];
    p  = lp ? rp : ~rp;
    n  = dt ? (ln ? rn : ~rn) : ~p;
    return {p, n};
  endfunction

  task automatic sweep_pins(input string req, input logic [7:0] r, input logic ap,
                            input logic an, input logic dt);
    alt_lvl_p = ap; alt_lvl_n = an; dt_en = dt;
    for (int k = 0; k < 4; k++) begin
      raw_pos = k[1]; raw_neg = k[0];
      #1;
      check(req, {6'd0, out_pos, out_neg}, {6'd0, exp_pins(r, ap, an, k[1], k[0], dt)});
    end
  endtask

  task automatic t_reset();
    do_por();
    check("R1 reg", rdata, 8'h00);
    check("R1 tgl", {7'd0, tgl_out}, 8'h00);
    dt_en = 1'b1; raw_pos = 1'b1; raw_neg = 1'b0; #1;
    check("R1 pins", {6'd0, out_pos, out_neg}, 8'h01);
  endtask

  task automatic t_fields();
    do_por();
    do_write(8'hB0);
    check("R2 rsvd only", rdata, 8'h00);
    do_write(8'h47);
    check("R3 write", rdata, 8'h47);
    do_write(8'hF7);
    check("R2 rsvd mixed", rdata, 8'h47);
    do_write(8'h00);
    check("R3 clear", rdata, 8'h00);
  endtask

  task automatic t_polarity();
    do_por();
    do_write(8'h03); sweep_pins("R7 pass", 8'h03, 1'b0, 1'b0, 1'b1);
    do_write(8'h00); sweep_pins("R7 invert", 8'h00, 1'b1, 1'b1, 1'b1);
    do_write(8'h01); sweep_pins("R7 mixed", 8'h01, 1'b0, 1'b1, 1'b1);
    do_write(8'h04); sweep_pins("R6 alt 10", 8'h04, 1'b1, 1'b0, 1'b1);
    do_write(8'h07); sweep_pins("R6 alt 00", 8'h07, 1'b0, 1'b0, 1'b1);
    do_write(8'h01); sweep_pins("R8 nodt a", 8'h01, 1'b0, 1'b0, 1'b0);
    do_write(8'h03); sweep_pins("R8 nodt b", 8'h03, 1'b0, 1'b0, 1'b0);
    do_write(8'h02); sweep_pins("R8 nodt c", 8'h02, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_toggle();
    do_por();
    do_write(8'h40);
    check("R10 start", {7'd0, tgl_out}, 8'h00);
    strobe(); check("R9 s1", {7'd0, tgl_out}, 8'h01);
    strobe(); check("R9 s2", {7'd0, tgl_out}, 8'h00);
    strobe(); check("R9 s3", {7'd0, tgl_out}, 8'h01);
    repeat (3) @(negedge clk);
    check("R9 hold", {7'd0, tgl_out}, 8'h01);
    do_write(8'h00);
    @(negedge clk);
    check("R10 off", {7'd0, tgl_out}, 8'h00);
    strobe(); check("R10 ignore strb", {7'd0, tgl_out}, 8'h00);
    do_write(8'h40);
    check("R10 resume 0", {7'd0, tgl_out}, 8'h00);
    strobe(); check("R10 resume 1", {7'd0, tgl_out}, 8'h01);
  endtask

  task automatic t_lock();
    do_por();
    do_write(8'h0B);
    check("R4 set", rdata, 8'h0B);
    do_write(8'h44);
    check("R5 guard+free", rdata, 8'h4B);
    do_write(8'h00);
    check("R4 keep", rdata, 8'h0B);
    sweep_pins("R5 pins", 8'h0B, 1'b0, 1'b0, 1'b1);
    do_write(8'h40);
    // soft reset
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 soft", rdata, 8'h08);
    check("R11 tgl", {7'd0, tgl_out}, 8'h00);
    do_write(8'h07);
    check("R11 still locked", rdata, 8'h08);
    do_por();
    check("R11 por", rdata, 8'h00);
    do_write(8'h03);
    check("R11 unlocked", rdata, 8'h03);
  endtask

  initial begin
    por_n = 1'b0; rst_n = 1'b1; wr_en = 1'b0; wdata = '0;
    dt_en = 1'b1; raw_pos = 1'b0; raw_neg = 1'b0;
    alt_lvl_p = 1'b0; alt_lvl_n = 1'b0; period_strb = 1'b0;
    t_reset();
    t_fields();
    t_polarity();
    t_toggle();
    t_lock();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule